// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block sits beside an 8-bit processor core and decides which of seven peripheral interrupt requests is handed to the core, and when. Requests are captured into pending flags on every clock. A master enable bit and one enable bit per source gate which pending flags may compete. Each source carries a four-step priority level, assembled from one bit in a "low" level register and one bit in a "high" level register.

The controller also tracks which levels have service routines in progress, one in-service flag per level. A new request is offered to the core only when its level is strictly above every level already in service. The core acknowledges an offered request, which moves it from pending to in-service. At the end of a routine, the core pulses a return strobe, which retires the innermost level. The offered request is reported as a source index and its level. Fetching the vector from that index is left to the core.

Top module: `intc_nested_prio`

## Requirements
- R1: After reset, all three registers read 0x00, no request is offered (`irq_valid`=0), and no level is in service.
- R2: Register address 0 is the enable register, address 1 holds the low level bit per source, address 2 holds the high level bit per source. In both level registers, bit i belongs to source i, and bit 7 always reads 0. Address 3 reads 0x00. A write becomes visible on `reg_rdata` after the clock edge on which `reg_wr` is high.
- R3: Enable bit 7 is the master enable. While it is 0 nothing is offered. While it is 1, source i may compete only if enable bit i is 1. Source numbering: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2, 6 PCA.
- R4: A one-cycle pulse on `irq_req[i]` sets a pending flag for source i. The flag holds until the source is acknowledged. A pending flag of a disabled source is kept, and the source is offered once it is enabled.
- R5: The level of source i is {high[i], low[i]}, where 0 is the lowest and 3 the highest. Among competing sources, one at a higher level always wins.
- R6: Among competing sources at the same level, the lowest source index wins.
- R7: `irq_valid`, `irq_index` and `irq_level` follow the registered state combinationally. A request sampled at one clock edge can be offered right after that edge, and is not offered before it.
- R8: `irq_ack` while `irq_valid` is high clears the offered source's pending flag and sets the in-service flag of its level. A request for the same source in that same cycle leaves the flag pending.
- R9: A request is offered only if its level is strictly above the highest in-service level. A request at an equal or lower level waits. While level 3 is in service, nothing is offered.
- R10: `irq_reti` clears only the highest set in-service flag. It has no effect when no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 enable, 1 low level bits, 2 high level bits |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq_req | input | 7 | Interrupt request per source, sampled every clock |
| irq_ack | input | 1 | Core accepts the offered request |
| irq_reti | input | 1 | Core returns from the current service routine |
| irq_valid | output | 1 | A request is offered |
| irq_index | output | 3 | Source index of the offered request |
| irq_level | output | 2 | Level of the offered request |

## Verification
The arbiter is driven with request sets that the master enable gates off entirely, and with sets that only some source enables let through; these separate the global gate from the per-source gates. Mixed-level sets show whether a higher level wins regardless of index. Same-level sets with varied members show whether the fixed polling order picks the lowest index. A directed nesting sequence stacks three levels, then retires them one by one, and separates the strict-higher preemption rule from a greater-or-equal rule and the innermost-first retirement from any other clearing order. A simultaneous acknowledge and re-request shows whether the new request survives the clear.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // Width of one source's priority level and number of levels
  localparam int LVL_BITS = 2;
  localparam int NUM_LVL  = 1 << LVL_BITS;

  typedef logic [LVL_BITS-1:0] lvl_t;

  // Register select codes
  typedef enum logic [1:0] {
    REG_ENABLE = 2'd0,
    REG_LVL_LO = 2'd1,
    REG_LVL_HI = 2'd2,
    REG_UNUSED = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [1:0]         addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               en_global,
  output logic [NUM_SRC-1:0] en_src,
  output logic [NUM_SRC-1:0] lvl_lo,
  output logic [NUM_SRC-1:0] lvl_hi
);
  logic               glb_q, glb_d;
  logic [NUM_SRC-1:0] en_q, en_d;
  logic [NUM_SRC-1:0] lo_q, lo_d;
  logic [NUM_SRC-1:0] hi_q, hi_d;
  logic               ce_en, ce_lo, ce_hi;
  reg_sel_e           sel;

  assign sel   = reg_sel_e'(addr);
  assign ce_en = wr && (sel == REG_ENABLE);
  assign ce_lo = wr && (sel == REG_LVL_LO);
  assign ce_hi = wr && (sel == REG_LVL_HI);

  always_comb begin
    glb_d = glb_q;
    en_d  = en_q;
    lo_d  = lo_q;
    hi_d  = hi_q;
    if (ce_en) begin
      glb_d = wdata[DATA_W-1];
      en_d  = wdata[NUM_SRC-1:0];
    end
    if (ce_lo) lo_d = wdata[NUM_SRC-1:0];
    if (ce_hi) hi_d = wdata[NUM_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_q <= 1'b0;
      en_q  <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else begin
      glb_q <= glb_d;
      en_q  <= en_d;
      lo_q  <= lo_d;
      hi_q  <= hi_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      REG_ENABLE: begin
        rdata[DATA_W-1]    = glb_q;
        rdata[NUM_SRC-1:0] = en_q;
      end
      REG_LVL_LO: rdata[NUM_SRC-1:0] = lo_q;
      REG_LVL_HI: rdata[NUM_SRC-1:0] = hi_q;
      default:    rdata = '0;
    endcase
  end

  assign en_global = glb_q;
  assign en_src    = en_q;
  assign lvl_lo    = lo_q;
  assign lvl_hi    = hi_q;
endmodule

// File: rtl/intc_pending.sv
module intc_pending #(
  parameter int NUM_SRC = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] pend
);
  logic [NUM_SRC-1:0] pend_q, pend_d;

  // A fresh request outranks the clear of the same source
  always_comb begin
    pend_d = (pend_q & ~clr) | req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 7,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] pend,
  input  logic               en_global,
  input  logic [NUM_SRC-1:0] en_src,
  input  logic [NUM_SRC-1:0] lvl_lo,
  input  logic [NUM_SRC-1:0] lvl_hi,
  input  logic               busy,
  input  lvl_t               busy_lvl,
  output logic               valid,
  output logic [IDX_W-1:0]   idx,
  output lvl_t               lvl
);
  lvl_t               src_lvl [NUM_SRC];
  logic [NUM_SRC-1:0] elig;
  logic               found;
  logic [IDX_W-1:0]   best_idx;
  lvl_t               best_lvl;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl
    assign src_lvl[g] = {lvl_hi[g], lvl_lo[g]};
  end

  assign elig = pend & en_src & {NUM_SRC{en_global}};

  // Ascending scan: strictly-greater replacement keeps the lowest index on ties
  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_lvl = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!found || (src_lvl[i] > best_lvl))) begin
        found    = 1'b1;
        best_idx = IDX_W'(i);
        best_lvl = src_lvl[i];
      end
    end
  end

  assign valid = found && (!busy || (best_lvl > busy_lvl));
  assign idx   = best_idx;
  assign lvl   = best_lvl;
endmodule

// File: rtl/intc_nest.sv
module intc_nest
  import intc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  lvl_t               take_lvl,
  input  logic               ret,
  output logic               busy,
  output lvl_t               busy_lvl,
  output logic [NUM_LVL-1:0] isr
);
  logic [NUM_LVL-1:0] isr_q, isr_d;
  logic [NUM_LVL-1:0] top_mask;
  logic [NUM_LVL-1:0] set_mask;

  always_comb begin
    top_mask = '0;
    busy_lvl = '0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (isr_q[i]) begin
        top_mask = '0;
        top_mask[i] = 1'b1;
        busy_lvl = lvl_t'(i);
      end
    end
  end

  assign busy = |isr_q;

  always_comb begin
    set_mask = '0;
    if (take) set_mask[take_lvl] = 1'b1;
  end

  always_comb begin
    isr_d = isr_q;
    if (ret)  isr_d = isr_d & ~top_mask;
    if (take) isr_d = isr_d | set_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= isr_d;
  end

  assign isr = isr_q;
endmodule

// File: rtl/intc_nested_prio.sv
module intc_nested_prio
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int DATA_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic [1:0]                 reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  input  logic [NUM_SRC-1:0]         irq_req,
  input  logic                       irq_ack,
  input  logic                       irq_reti,
  output logic                       irq_valid,
  output logic [$clog2(NUM_SRC)-1:0] irq_index,
  output logic [LVL_BITS-1:0]        irq_level
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [1:0]         rst_sync_q;
  logic               rst_sync_n;
  logic               en_global;
  logic [NUM_SRC-1:0] en_src;
  logic [NUM_SRC-1:0] lvl_lo;
  logic [NUM_SRC-1:0] lvl_hi;
  logic [NUM_SRC-1:0] pend_vec;
  logic [NUM_SRC-1:0] clr_vec;
  logic [NUM_LVL-1:0] isr_vec;
  logic               busy;
  lvl_t               busy_lvl;
  logic               take;
  logic               arb_valid;
  logic [IDX_W-1:0]   arb_idx;
  lvl_t               arb_lvl;

  // Asserted at once, released after two clean edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  intc_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr        (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .en_global (en_global),
    .en_src    (en_src),
    .lvl_lo    (lvl_lo),
    .lvl_hi    (lvl_hi)
  );

  assign take = irq_ack && arb_valid;

  always_comb begin
    clr_vec = '0;
    if (take) clr_vec[arb_idx] = 1'b1;
  end

  intc_pending #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .req   (irq_req),
    .clr   (clr_vec),
    .pend  (pend_vec)
  );

  intc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .pend      (pend_vec),
    .en_global (en_global),
    .en_src    (en_src),
    .lvl_lo    (lvl_lo),
    .lvl_hi    (lvl_hi),
    .busy      (busy),
    .busy_lvl  (busy_lvl),
    .valid     (arb_valid),
    .idx       (arb_idx),
    .lvl       (arb_lvl)
  );

  intc_nest u_nest (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .take     (take),
    .take_lvl (arb_lvl),
    .ret      (irq_reti),
    .busy     (busy),
    .busy_lvl (busy_lvl),
    .isr      (isr_vec)
  );

  assign irq_valid = arb_valid;
  assign irq_index = arb_idx;
  assign irq_level = arb_lvl;
endmodule

// File: rtl/intc_nested_prio_chk.sv
module intc_nested_prio_chk
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 7
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_SRC-1:0]         irq_req,
  input logic                       irq_ack,
  input logic                       irq_reti,
  input logic                       irq_valid,
  input logic [$clog2(NUM_SRC)-1:0] irq_index,
  input logic [LVL_BITS-1:0]        irq_level,
  input logic                       en_global,
  input logic [NUM_SRC-1:0]         en_src,
  input logic [NUM_SRC-1:0]         pend_vec,
  input logic [NUM_LVL-1:0]         isr_vec
);
  // R3
  offer_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (en_global && en_src[irq_index] && pend_vec[irq_index]));

  // R9
  strict_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ((isr_vec >> irq_level) == '0));

  // R9
  top_level_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isr_vec[NUM_LVL-1] |-> !irq_valid);

  // R8
  ack_sets_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_valid) |=> isr_vec[$past(irq_level)]);

  // R8
  ack_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_valid && !irq_req[irq_index]) |=> !pend_vec[$past(irq_index)]);

  // R10
  reti_pops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_reti && !(irq_ack && irq_valid) && (isr_vec != '0)) |=>
      ($countones(isr_vec) == $countones($past(isr_vec)) - 1));
endmodule

bind intc_nested_prio intc_nested_prio_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .irq_req   (irq_req),
  .irq_ack   (irq_ack),
  .irq_reti  (irq_reti),
  .irq_valid (irq_valid),
  .irq_index (irq_index),
  .irq_level (irq_level),
  .en_global (en_global),
  .en_src    (en_src),
  .pend_vec  (pend_vec),
  .isr_vec   (isr_vec)
);

// File: tb/tb_intc_nested_prio.sv
module tb_intc_nested_prio;
  logic       clk;
  logic       rst_n;
  logic       reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [6:0] irq_req;
  logic       irq_ack;
  logic       irq_reti;
  logic       irq_valid;
  logic [2:0] irq_index;
  logic [1:0] irq_level;

  int  n_chk;
  int  n_err;
  bit  done;

  intc_nested_prio dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
    .irq_ack(irq_ack), .irq_reti(irq_reti), .irq_valid(irq_valid),
    .irq_index(irq_index), .irq_level(irq_level)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [7:0] en;
    logic [7:0] lo;
    logic [7:0] hi;
    logic [6:0] req;
    logic       v;
    logic [2:0] idx;
    logic [1:0] lvl;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h80, 8'h00, 8'h00, 7'h7F, 1'b0, 3'd0, 2'd0},  // R3 master on, no source enabled
    '{8'hFF, 8'h00, 8'h00, 7'h7F, 1'b1, 3'd0, 2'd0},  // R6 all level 0
    '{8'hFF, 8'h00, 8'h00, 7'h60, 1'b1, 3'd5, 2'd0},  // R6
    '{8'hFF, 8'h40, 8'h00, 7'h41, 1'b1, 3'd6, 2'd1},  // R5
    '{8'hFF, 8'h00, 8'h08, 7'h0F, 1'b1, 3'd3, 2'd2},  // R5
    '{8'hFF, 8'h14, 8'h14, 7'h14, 1'b1, 3'd2, 2'd3},  // R6 tie at level 3
    '{8'h7F, 8'h00, 8'h00, 7'h7F, 1'b0, 3'd0, 2'd0},  // R3 master off
    '{8'h84, 8'h00, 8'h00, 7'h7F, 1'b1, 3'd2, 2'd0},  // R3 one source enabled
    '{8'hFF, 8'h30, 8'h20, 7'h30, 1'b1, 3'd5, 2'd3},  // R5
    '{8'hFF, 8'h0A, 8'h0A, 7'h0B, 1'b1, 3'd1, 2'd3}   // R5 R6
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    irq_req = 0; irq_ack = 0; irq_reti = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input int exp);
    @(negedge clk);
    reg_addr = a;
    #2;
    chk(tag, int'(reg_rdata), exp);
  endtask

  task automatic pulse_req(input logic [6:0] r);
    @(negedge clk);
    irq_req = r;
    @(negedge clk);
    irq_req = '0;
  endtask

  task automatic pulse_ack(input logic [6:0] r);
    @(negedge clk);
    irq_ack = 1'b1; irq_req = r;
    @(negedge clk);
    irq_ack = 1'b0; irq_req = '0;
  endtask

  task automatic pulse_reti();
    @(negedge clk);
    irq_reti = 1'b1;
    @(negedge clk);
    irq_reti = 1'b0;
  endtask

  task automatic chk_offer(input string tag, input bit v, input int idx, input int lvl);
    #2;
    chk({tag, " valid"}, int'(irq_valid), int'(v));
    if (v) begin
      chk({tag, " index"}, int'(irq_index), idx);
      chk({tag, " level"}, int'(irq_level), lvl);
    end
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_err = 0; done = 0;
    rst_n = 1'b0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    irq_req = 0; irq_ack = 0; irq_reti = 0;

    // Vector table: arbitration under varied enables and levels
    for (int k = 0; k < NV; k++) begin
      do_reset();
      wr_reg(2'd0, VECS[k].en);
      wr_reg(2'd1, VECS[k].lo);
      wr_reg(2'd2, VECS[k].hi);
      pulse_req(VECS[k].req);
      chk_offer($sformatf("R5/R6/R3 vec%0d", k), VECS[k].v, int'(VECS[k].idx), int'(VECS[k].lvl));
    end

    // R1 reset state
    do_reset();
    rd_chk("R1 enable reset", 2'd0, 0);
    rd_chk("R1 low reset", 2'd1, 0);
    rd_chk("R1 high reset", 2'd2, 0);
    #2 chk("R1 no offer", int'(irq_valid), 0);

    // R2 register access
    wr_reg(2'd1, 8'hFF);
    rd_chk("R2 low bit7 reads 0", 2'd1, 8'h7F);
    wr_reg(2'd2, 8'h55);
    rd_chk("R2 high readback", 2'd2, 8'h55);
    wr_reg(2'd3, 8'hFF);
    rd_chk("R2 unused address", 2'd3, 0);
    wr_reg(2'd0, 8'hA5);
    rd_chk("R2 enable readback", 2'd0, 8'hA5);

    // R7 offer appears only after the sampling edge
    do_reset();
    wr_reg(2'd0, 8'hFF);
    @(negedge clk);
    irq_req = 7'h10;
    #2 chk("R7 before edge", int'(irq_valid), 0);
    @(negedge clk);
    irq_req = '0;
    chk_offer("R7 after edge", 1'b1, 4, 0);

    // R4 disabled pending flag is kept
    do_reset();
    wr_reg(2'd0, 8'h80);
    pulse_req(7'h02);
    chk_offer("R4 disabled", 1'b0, 0, 0);
    repeat (3) @(negedge clk);
    wr_reg(2'd0, 8'h82);
    chk_offer("R4 enabled later", 1'b1, 1, 0);

    // Nesting: src0 lvl1, src1 lvl2, src2 lvl1, src3 lvl3
    do_reset();
    wr_reg(2'd0, 8'hFF);
    wr_reg(2'd1, 8'h0D);
    wr_reg(2'd2, 8'h0A);
    pulse_req(7'h01);
    chk_offer("R9 first offer", 1'b1, 0, 1);
    pulse_ack(7'h00);
    chk_offer("R8 pending cleared", 1'b0, 0, 0);
    pulse_req(7'h04);
    chk_offer("R9 equal level waits", 1'b0, 0, 0);
    pulse_req(7'h02);
    chk_offer("R9 higher preempts", 1'b1, 1, 2);
    pulse_ack(7'h00);
    chk_offer("R9 lvl1 under lvl2", 1'b0, 0, 0);
    pulse_req(7'h08);
    chk_offer("R9 lvl3 preempts", 1'b1, 3, 3);
    pulse_ack(7'h00);
    pulse_req(7'h02);
    chk_offer("R9 lvl3 blocks all", 1'b0, 0, 0);
    pulse_reti();
    chk_offer("R10 lvl2 still busy", 1'b0, 0, 0);
    pulse_reti();
    chk_offer("R10 lvl1 remains", 1'b1, 1, 2);
    pulse_reti();
    chk_offer("R10 empty stack", 1'b1, 1, 2);
    pulse_reti();
    chk_offer("R10 no effect when idle", 1'b1, 1, 2);

    // R8 acknowledge with a same-cycle re-request
    do_reset();
    wr_reg(2'd0, 8'hFF);
    pulse_req(7'h10);
    chk_offer("R8 offered", 1'b1, 4, 0);
    pulse_ack(7'h10);
    chk_offer("R8 blocked by own level", 1'b0, 0, 0);
    pulse_reti();
    chk_offer("R8 re-request kept", 1'b1, 4, 0);
    pulse_ack(7'h00);
    pulse_reti();
    chk_offer("R8 plain ack clears", 1'b0, 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule